// File: doc/BRIEF.md
# PCI Single-Word Write Initiator

This block turns one write from a local CPU bus into a single PCI write transaction that the CPU waits on. The CPU presents an address strobe with address, data, byte enables and a memory/I-O select. The block latches the request, lets it travel through a fixed-latency synchronizer, requests the PCI bus, waits for grant and an idle bus, and then runs one address phase and one data phase. It returns ready to the CPU only after the target has really accepted the data.

Target wait states are absorbed without limit once the target has claimed the cycle. A retry from the target (STOP without TRDY) ends the attempt. The block then leaves the bus for at least one idle clock and reissues exactly the same transaction, and it keeps doing so until the target completes it. The CPU sees none of this and simply keeps waiting. If no target claims the cycle, the block ends it as a master abort and reports ready together with an error flag.

Top module: `pciw_write_bridge`

## Requirements
- R1: A write is captured on a clock edge where `cpu_ads` is 1 and no write is pending. It then passes through `SYNC_STAGES` register stages, and `pci_req_n` goes low on the clock edge `SYNC_STAGES` edges after the capture edge.
- R2: `pci_req_n` is driven low only for a captured write, either after the synchronizer or after a retry gap. It returns high on the edge where FRAME is asserted.
- R3: `pci_frame_n` falls only on an edge where `pci_gnt_n` is 0 and the bus is idle (`pci_frame_in_n` and `pci_irdy_in_n` both 1). With grant parked on the block, it falls on the edge right after `pci_req_n` went low.
- R4: FRAME stays low for exactly one clock, and `pci_irdy_n` is low from the next clock. Once DEVSEL has been seen, IRDY stays low through any number of target wait states (16 or more) until TRDY or STOP is sampled low.
- R5: In the address phase `pci_ad` carries the captured address and `pci_cbe` carries 4'b0111 for a memory write (`cpu_io`=0) or 4'b0011 for an I/O write (`cpu_io`=1). In the data phase `pci_ad` carries the data and `pci_cbe` is the bitwise inverse of `cpu_be`, where `cpu_be` bit i = 1 enables byte i.
- R6: TRDY low with IRDY low completes the transfer. STOP low with TRDY high is a retry: the attempt ends, `pci_req_n` stays high for the turnaround clock and one more idle clock, and the identical address, command, data and byte enables are then issued again.
- R7: `cpu_rdy` is a one-clock pulse. It rises `SYNC_STAGES` edges after the edge at which the completion (or master abort) is sampled, and never at any other time, including during retries.
- R8: If DEVSEL is not sampled low within `DEVSEL_CLKS` clocks counted from the FRAME clock, the block ends the cycle. It then raises `cpu_err` together with `cpu_rdy` and goes back to idle. A normal completion gives `cpu_err` = 0.
- R9: `pci_ad_oe` is 1 only from the address phase through the last data-phase clock and is 0 in the turnaround clock. `pci_ctl_oe` stays 1 through the turnaround clock, with FRAME and IRDY driven high there, and is then released.
- R10: `cpu_ads` and the CPU address, data, byte-enable and select inputs are ignored while a write is pending. The transaction carries the values captured at the accepting edge.
- R11: After synchronous reset: `pci_req_n`, `pci_frame_n` and `pci_irdy_n` are 1, both output enables are 0, and `cpu_rdy` and `cpu_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by CPU side and PCI side |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ads | input | 1 | CPU write strobe |
| cpu_addr | input | 32 | Write address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables, active high |
| cpu_io | input | 1 | 1 selects an I/O write, 0 a memory write |
| cpu_rdy | output | 1 | One-clock completion pulse to the CPU |
| cpu_err | output | 1 | Master abort flag, valid with cpu_rdy |
| pci_req_n | output | 1 | Bus request to the arbiter |
| pci_gnt_n | input | 1 | Bus grant from the arbiter |
| pci_frame_in_n | input | 1 | FRAME as seen on the bus |
| pci_irdy_in_n | input | 1 | IRDY as seen on the bus |
| pci_devsel_n | input | 1 | Target claim |
| pci_trdy_n | input | 1 | Target ready |
| pci_stop_n | input | 1 | Target stop |
| pci_frame_n | output | 1 | FRAME drive value |
| pci_irdy_n | output | 1 | IRDY drive value |
| pci_ctl_oe | output | 1 | Output enable for FRAME and IRDY |
| pci_ad | output | 32 | Address/data drive value |
| pci_cbe | output | 4 | Command / byte-enable drive value |
| pci_ad_oe | output | 1 | Output enable for AD and C/BE |

## Verification
The assertions check the following on every cycle: FRAME falls only after grant with an idle bus, FRAME lasts one clock and is followed by IRDY, IRDY is held while a claiming target inserts waits, AD is released after TRDY, ready comes only for a pending write and only as a pulse, an abort coincides with DEVSEL absent, and the captured request stays stable while pending. Other properties depend on whole sequences and are shown only by the bench scenarios: that a retry reissues the identical transaction after an idle gap, that ready follows completion by exactly the synchronizer depth, that a late grant or a busy bus delays FRAME, and that a strobe during a pending write leaves no trace on the bus.

// File: rtl/pciw_pkg.sv
package pciw_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    localparam logic [3:0] CMD_IO_WRITE  = 4'b0011;
    localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_TURN,
        ST_GAP
    } ini_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
        logic              io;
    } wr_req_t;

    function automatic logic [3:0] wr_command(input logic io);
        return io ? CMD_IO_WRITE : CMD_MEM_WRITE;
    endfunction

    function automatic logic [BE_W-1:0] bus_byte_en(input logic [BE_W-1:0] be);
        return ~be;
    endfunction

endpackage

// File: rtl/pciw_sync_pipe.sv
module pciw_sync_pipe #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    if (STAGES == 1) begin : g_single
        logic [W-1:0] q_r;
        always_ff @(posedge clk) begin
            if (rst) q_r <= '0;
            else     q_r <= d;
        end
        assign q = q_r;
    end else begin : g_chain
        logic [STAGES*W-1:0] sr;
        always_ff @(posedge clk) begin
            if (rst) sr <= '0;
            else     sr <= {sr[(STAGES-1)*W-1:0], d};
        end
        assign q = sr[STAGES*W-1 -: W];
    end

endmodule

// File: rtl/pciw_cpu_port.sv
module pciw_cpu_port
    import pciw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_ads,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic              cpu_io,
    input  logic              ini_done,
    input  logic              ini_err,
    output wr_req_t           req_hold,
    output logic              go,
    output logic              cpu_rdy,
    output logic              cpu_err
);

    logic       pending;
    logic       accept;
    logic [1:0] back_q;

    assign accept = cpu_ads && !pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 1'b0;
            req_hold <= '0;
        end else begin
            if (cpu_rdy) pending <= 1'b0;
            if (accept) begin
                pending  <= 1'b1;
                req_hold <= '{addr: cpu_addr, data: cpu_wdata, be: cpu_be, io: cpu_io};
            end
        end
    end

    pciw_sync_pipe #(.STAGES(SYNC_STAGES), .W(1)) u_fwd (
        .clk (clk),
        .rst (rst),
        .d   (accept),
        .q   (go)
    );

    pciw_sync_pipe #(.STAGES(SYNC_STAGES), .W(2)) u_back (
        .clk (clk),
        .rst (rst),
        .d   ({ini_err, ini_done}),
        .q   (back_q)
    );

    assign cpu_rdy = back_q[0];
    assign cpu_err = back_q[0] & back_q[1];

    AST_RDY_ONLY_PENDING: assert property (@(posedge clk) disable iff (rst)
        cpu_rdy |-> pending); // R7
    AST_RDY_IS_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_rdy |=> !cpu_rdy); // R7
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (pending && !cpu_rdy) |=> $stable(req_hold)); // R10

endmodule

// File: rtl/pciw_initiator.sv
module pciw_initiator
    import pciw_pkg::*;
#(
    parameter int DEVSEL_CLKS = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  wr_req_t           wreq,
    input  logic              gnt_n,
    input  logic              frame_in_n,
    input  logic              irdy_in_n,
    input  logic              devsel_n,
    input  logic              trdy_n,
    input  logic              stop_n,
    output logic              req_n,
    output logic              frame_n,
    output logic              irdy_n,
    output logic              ctl_oe,
    output logic [DATA_W-1:0] ad,
    output logic [3:0]        cbe,
    output logic              ad_oe,
    output logic              done,
    output logic              err
);

    localparam int CNT_W = $clog2(DEVSEL_CLKS);
    localparam logic [CNT_W-1:0] ABORT_AT = CNT_W'(DEVSEL_CLKS - 2);

    ini_state_e       state;
    logic [CNT_W-1:0] dcnt;
    logic             seen;
    logic             retry_f;
    logic             seen_now;
    logic             bus_free;

    assign seen_now = seen || !devsel_n;
    assign bus_free = !gnt_n && frame_in_n && irdy_in_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            req_n   <= 1'b1;
            frame_n <= 1'b1;
            irdy_n  <= 1'b1;
            ctl_oe  <= 1'b0;
            ad      <= '0;
            cbe     <= '0;
            ad_oe   <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
            dcnt    <= '0;
            seen    <= 1'b0;
            retry_f <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        req_n <= 1'b0;
                        state <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (bus_free) begin
                        req_n   <= 1'b1;
                        frame_n <= 1'b0;
                        ctl_oe  <= 1'b1;
                        ad_oe   <= 1'b1;
                        ad      <= wreq.addr;
                        cbe     <= wr_command(wreq.io);
                        state   <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    frame_n <= 1'b1;
                    irdy_n  <= 1'b0;
                    ad      <= wreq.data;
                    cbe     <= bus_byte_en(wreq.be);
                    dcnt    <= '0;
                    seen    <= 1'b0;
                    state   <= ST_DATA;
                end
                ST_DATA: begin
                    if (!trdy_n || !stop_n || (!seen_now && dcnt == ABORT_AT)) begin
                        irdy_n  <= 1'b1;
                        ad_oe   <= 1'b0;
                        state   <= ST_TURN;
                        retry_f <= trdy_n && !stop_n;
                        done    <= !trdy_n || stop_n;
                        err     <= trdy_n && stop_n;
                    end else begin
                        seen <= seen_now;
                        if (!seen_now) dcnt <= dcnt + 1'b1;
                    end
                end
                ST_TURN: begin
                    ctl_oe <= 1'b0;
                    state  <= retry_f ? ST_GAP : ST_IDLE;
                end
                ST_GAP: begin
                    req_n <= 1'b0;
                    state <= ST_REQ;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_FRAME_NEEDS_GNT: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_n) |-> $past(!gnt_n && frame_in_n && irdy_in_n)); // R3
    AST_ONE_ADDR_CLOCK: assert property (@(posedge clk) disable iff (rst)
        !frame_n |=> (frame_n && !irdy_n)); // R4
    AST_IRDY_WAITS: assert property (@(posedge clk) disable iff (rst)
        (!irdy_n && trdy_n && stop_n && !devsel_n) |=> !irdy_n); // R4
    AST_AD_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (!irdy_n && !trdy_n) |=> !ad_oe); // R9
    AST_ABORT_NO_DEVSEL: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> $past(devsel_n)); // R8

endmodule

// File: rtl/pciw_write_bridge.sv
module pciw_write_bridge
    import pciw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEVSEL_CLKS = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_ads,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic              cpu_io,
    output logic              cpu_rdy,
    output logic              cpu_err,
    output logic              pci_req_n,
    input  logic              pci_gnt_n,
    input  logic              pci_frame_in_n,
    input  logic              pci_irdy_in_n,
    input  logic              pci_devsel_n,
    input  logic              pci_trdy_n,
    input  logic              pci_stop_n,
    output logic              pci_frame_n,
    output logic              pci_irdy_n,
    output logic              pci_ctl_oe,
    output logic [DATA_W-1:0] pci_ad,
    output logic [3:0]        pci_cbe,
    output logic              pci_ad_oe
);

    wr_req_t req_hold;
    logic    go;
    logic    ini_done;
    logic    ini_err;

    pciw_cpu_port #(.SYNC_STAGES(SYNC_STAGES)) u_cpu (
        .clk       (clk),
        .rst       (rst),
        .cpu_ads   (cpu_ads),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_be    (cpu_be),
        .cpu_io    (cpu_io),
        .ini_done  (ini_done),
        .ini_err   (ini_err),
        .req_hold  (req_hold),
        .go        (go),
        .cpu_rdy   (cpu_rdy),
        .cpu_err   (cpu_err)
    );

    pciw_initiator #(.DEVSEL_CLKS(DEVSEL_CLKS)) u_ini (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .wreq       (req_hold),
        .gnt_n      (pci_gnt_n),
        .frame_in_n (pci_frame_in_n),
        .irdy_in_n  (pci_irdy_in_n),
        .devsel_n   (pci_devsel_n),
        .trdy_n     (pci_trdy_n),
        .stop_n     (pci_stop_n),
        .req_n      (pci_req_n),
        .frame_n    (pci_frame_n),
        .irdy_n     (pci_irdy_n),
        .ctl_oe     (pci_ctl_oe),
        .ad         (pci_ad),
        .cbe        (pci_cbe),
        .ad_oe      (pci_ad_oe),
        .done       (ini_done),
        .err        (ini_err)
    );

endmodule

// File: tb/tb_pciw_write_bridge.sv
module tb_pciw_write_bridge;

    localparam int STG  = 2;
    localparam int DSEL = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        cpu_ads = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_io = 1'b0;
    logic        cpu_rdy, cpu_err;
    logic        pci_req_n, pci_frame_n, pci_irdy_n, pci_ctl_oe, pci_ad_oe;
    logic [31:0] pci_ad;
    logic [3:0]  pci_cbe;
    logic        pci_gnt_n = 1'b0;
    logic        pci_devsel_n = 1'b1, pci_trdy_n = 1'b1, pci_stop_n = 1'b1;
    logic        other_busy = 1'b0;
    logic        pci_frame_in_n, pci_irdy_in_n;

    assign pci_frame_in_n = pci_ctl_oe ? pci_frame_n : ~other_busy;
    assign pci_irdy_in_n  = pci_ctl_oe ? pci_irdy_n  : ~other_busy;

    pciw_write_bridge #(.SYNC_STAGES(STG), .DEVSEL_CLKS(DSEL)) dut (
        .clk(clk), .rst(rst), .cpu_ads(cpu_ads), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_io(cpu_io),
        .cpu_rdy(cpu_rdy), .cpu_err(cpu_err), .pci_req_n(pci_req_n),
        .pci_gnt_n(pci_gnt_n), .pci_frame_in_n(pci_frame_in_n),
        .pci_irdy_in_n(pci_irdy_in_n), .pci_devsel_n(pci_devsel_n),
        .pci_trdy_n(pci_trdy_n), .pci_stop_n(pci_stop_n),
        .pci_frame_n(pci_frame_n), .pci_irdy_n(pci_irdy_n),
        .pci_ctl_oe(pci_ctl_oe), .pci_ad(pci_ad), .pci_cbe(pci_cbe),
        .pci_ad_oe(pci_ad_oe)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    localparam int M_IDLE = 0, M_ASK = 1, M_ADR = 2, M_DAT = 3, M_TRN = 4, M_HOLD = 5;
    bit        fwdq[$];
    bit [1:0]  bckq[$];
    int        ph, dclk;
    bit        dseen, m_retry, m_pend;
    bit        m_req, m_frame, m_irdy, m_ctloe, m_adoe, m_rdy, m_err;
    bit [31:0] m_ad, c_addr, c_data;
    bit [3:0]  m_cbe, c_be;
    bit        c_io;

    always @(posedge clk) begin
        bit acc, go_m, dn, er, fin;
        bit [1:0] bq;
        if (rst) begin
            fwdq.delete(); bckq.delete();
            for (int i = 0; i < STG; i++) begin fwdq.push_back(1'b0); bckq.push_back(2'b00); end
            ph = M_IDLE; m_pend = 0; m_req = 1; m_frame = 1; m_irdy = 1;
            m_ctloe = 0; m_adoe = 0; m_rdy = 0; m_err = 0; m_retry = 0;
        end else begin
            acc = cpu_ads && !m_pend;
            if (m_rdy) m_pend = 0;
            if (acc) begin
                m_pend = 1; c_addr = cpu_addr; c_data = cpu_wdata; c_be = cpu_be; c_io = cpu_io;
            end
            go_m = fwdq.pop_front(); fwdq.push_back(acc);
            dn = 0; er = 0; fin = 0;
            case (ph)
                M_IDLE: if (go_m) begin m_req = 0; ph = M_ASK; end
                M_ASK: if (!pci_gnt_n && pci_frame_in_n && pci_irdy_in_n) begin
                    m_req = 1; m_frame = 0; m_ctloe = 1; m_adoe = 1;
                    m_ad = c_addr; m_cbe = c_io ? 4'b0011 : 4'b0111; ph = M_ADR;
                end
                M_ADR: begin
                    m_frame = 1; m_irdy = 0; m_ad = c_data; m_cbe = ~c_be;
                    dclk = 0; dseen = 0; ph = M_DAT;
                end
                M_DAT: begin
                    if (!pci_devsel_n) dseen = 1;
                    if (!pci_trdy_n) begin dn = 1; m_retry = 0; fin = 1; end
                    else if (!pci_stop_n) begin m_retry = 1; fin = 1; end
                    else if (!dseen && dclk == DSEL - 2) begin dn = 1; er = 1; m_retry = 0; fin = 1; end
                    else dclk++;
                    if (fin) begin m_irdy = 1; m_adoe = 0; ph = M_TRN; end
                end
                M_TRN: begin m_ctloe = 0; ph = m_retry ? M_HOLD : M_IDLE; end
                M_HOLD: begin m_req = 0; ph = M_ASK; end
                default: ph = M_IDLE;
            endcase
            bq = bckq.pop_front(); bckq.push_back({er, dn});
            m_rdy = bq[0]; m_err = bq[0] & bq[1];
        end
    end

    // ---------------- target / arbiter models and per-clock compare ----------------
    int  t_dsel = 0, t_ws = 0, t_retries = 0, tcnt = 0;
    bit  t_nodev = 0;
    bit  parked = 1;
    int  gnt_delay = 0, gcnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 req_n",    pci_req_n,   m_req);
            chk("R3 frame_n",  pci_frame_n, m_frame);
            chk("R4 irdy_n",   pci_irdy_n,  m_irdy);
            chk("R9 ctl_oe",   pci_ctl_oe,  m_ctloe);
            chk("R9 ad_oe",    pci_ad_oe,   m_adoe);
            chk("R7 cpu_rdy",  cpu_rdy,     m_rdy);
            chk("R8 cpu_err",  cpu_err,     m_err);
            if (m_adoe) begin
                chk("R5 ad",  pci_ad,  m_ad);
                chk("R5 cbe", pci_cbe, m_cbe);
            end
        end
        if (parked) pci_gnt_n = 1'b0;
        else if (!pci_req_n) begin gcnt++; pci_gnt_n = (gcnt < gnt_delay); end
        else begin gcnt = 0; pci_gnt_n = 1'b1; end
        if (pci_ctl_oe && !pci_irdy_n) begin
            tcnt++;
            pci_devsel_n = t_nodev || (tcnt <= t_dsel);
            if (!t_nodev && tcnt > t_ws) begin
                if (t_retries > 0) pci_stop_n = 1'b0;
                else               pci_trdy_n = 1'b0;
            end
        end else begin
            if (!pci_stop_n && t_retries > 0) t_retries--;
            tcnt = 0; pci_devsel_n = 1'b1; pci_trdy_n = 1'b1; pci_stop_n = 1'b1;
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wait_rdy(input bit exp_err, input string tag);
        int k = 0;
        while (!cpu_rdy && k < 3000) begin @(negedge clk); k++; end
        chk({tag, " rdy seen"}, cpu_rdy, 1'b1);
        chk({tag, " err flag"}, cpu_err, exp_err);
        repeat (4) @(negedge clk);
    endtask

    task automatic issue(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be, input logic io);
        @(negedge clk);
        cpu_ads = 1'b1; cpu_addr = a; cpu_wdata = d; cpu_be = be; cpu_io = io;
        @(negedge clk);
        cpu_ads = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 req_n reset",  pci_req_n,   1'b1);
        chk("R11 frame reset",  pci_frame_n, 1'b1);
        chk("R11 irdy reset",   pci_irdy_n,  1'b1);
        chk("R11 ctl_oe reset", pci_ctl_oe,  1'b0);
        chk("R11 ad_oe reset",  pci_ad_oe,   1'b0);
        chk("R11 rdy reset",    cpu_rdy,     1'b0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 R3 R5 R7: parked grant, memory write, no wait states
        t_dsel = 0; t_ws = 0; t_retries = 0; t_nodev = 0;
        issue(32'h1000_0040, 32'hDEAD_BEEF, 4'b1111, 1'b0);
        wait_rdy(1'b0, "R7 basic");

        // R3 R5: I/O write with late grant and partial byte enables
        parked = 0; gnt_delay = 4;
        issue(32'h0000_0CF8, 32'h8000_1234, 4'b0101, 1'b1);
        wait_rdy(1'b0, "R3 late grant");
        parked = 1;

        // R3: grant present but another master keeps the bus busy
        other_busy = 1'b1;
        issue(32'h2000_0000, 32'h0123_4567, 4'b0011, 1'b0);
        repeat (6) @(negedge clk);
        other_busy = 1'b0;
        wait_rdy(1'b0, "R3 busy bus");

        // R4: 16 target wait states after a slow claim
        t_dsel = 2; t_ws = 16;
        issue(32'h3000_0010, 32'hCAFE_F00D, 4'b1000, 1'b0);
        wait_rdy(1'b0, "R4 wait states");

        // R6: two retries then completion
        t_dsel = 0; t_ws = 1; t_retries = 2;
        issue(32'h4000_0004, 32'h5555_AAAA, 4'b1110, 1'b1);
        wait_rdy(1'b0, "R6 retry");
        chk("R6 retries consumed", t_retries, 0);

        // R8: no target claims the cycle
        t_nodev = 1; t_ws = 0;
        issue(32'h5000_0000, 32'h1111_2222, 4'b1111, 1'b0);
        wait_rdy(1'b1, "R8 abort");
        t_nodev = 0;

        // R10: second strobe with new values while the first is pending
        t_dsel = 1; t_ws = 3;
        issue(32'h6000_0100, 32'h7777_8888, 4'b1111, 1'b0);
        @(negedge clk);
        cpu_ads = 1'b1; cpu_addr = 32'h9999_0000; cpu_wdata = 32'h0; cpu_be = 4'b0000; cpu_io = 1'b1;
        @(negedge clk);
        cpu_ads = 1'b0;
        wait_rdy(1'b0, "R10 ignore ads");
        chk("R10 no second transfer", pci_req_n, 1'b1);

        // R1 R2: back-to-back writes
        t_dsel = 0; t_ws = 0;
        issue(32'h7000_0000, 32'hA5A5_A5A5, 4'b1100, 1'b0);
        wait_rdy(1'b0, "R1 back to back a");
        issue(32'h7000_0004, 32'h5A5A_5A5A, 4'b0011, 1'b0);
        wait_rdy(1'b0, "R1 back to back b");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule